// File: doc/BRIEF.md
# Settling-Gated Decimating FIR for a Multiplexed 1-Bit Modulator

This block filters and decimates the 1-bit stream of an oversampling modulator whose analog input passes through a channel multiplexer. The filter is a linear-phase FIR with symmetric, fixed triangular weights. Every DECIM accepted modulator bits it produces one signed output word. When the accumulated sum leaves the output range, the word is clipped to the nearest full-scale code.

A filter like this remembers its inputs. After the multiplexer moves to another channel, each output word mixes old-channel and new-channel bits until the whole delay line has been refilled. A request on the select port steers the multiplexer and returns a one-cycle acknowledge. It also restarts a settling count of NTAPS accepted bits and realigns the decimation phase. Output words are marked valid only after the count has run out, and each valid word carries the number of the channel that fed every tap.

Top module: `fir_flush_decim`

## Requirements
- R1: An input bit of 0 counts as -1 and a bit of 1 counts as +1. The output word equals the sum over taps i of w(i)*x(i), clipped. Tap 0 holds the newest accepted bit. The weights are w(i) = min(i+1, NTAPS-i), so w(i) = w(NTAPS-1-i).
- R2: A word is computed on the edge that accepts every DECIM-th bit after the last switch or reset. It is visible on `out_data` from that edge onward.
- R3: A sum above 2^(OUT_W-1)-1 produces exactly 2^(OUT_W-1)-1. With the defaults, a full line of ones (sum 1056) gives 511.
- R4: A sum below -2^(OUT_W-1) produces exactly -2^(OUT_W-1). With the defaults, a full line of zeros gives -512.
- R5: A clock edge with `sel_req` high loads `sel_ch` into `mux_sel`. `sel_ack` is high for exactly the one cycle after that edge.
- R6: After a switch, `out_valid` stays low for the first NTAPS-1 accepted bits. It rises one cycle after the edge that accepts the NTAPS-th bit.
- R7: A request that arrives during a flush restarts both the settling count and the decimation phase. NTAPS further bits must then be accepted before a valid word appears. `out_valid` is low in the cycle after any request.
- R8: Every valid word has `out_ch` equal to the channel that was selected during its whole settling window.
- R9: Synchronous reset sets every tap to bit 0, sets the settling count to NTAPS and the phase to 0, and sets `mux_sel`, `sel_ack`, `out_valid`, `out_ch` and `out_data` to 0.
- R10: A bit is accepted only when `bit_en` is high and `sel_req` is low. A bit offered in the same cycle as a request is dropped, and `bit_in` has no effect while `bit_en` is low.
- R11: Once settled, `out_valid` pulses for one cycle on every DECIM-th accepted bit and stays low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Qualifies `bit_in` as a new modulator bit |
| bit_in | input | 1 | Modulator output bit |
| sel_req | input | 1 | Channel switch request |
| sel_ch | input | CH_W | Requested channel number |
| sel_ack | output | 1 | Switch accepted, pulses for one cycle |
| mux_sel | output | CH_W | Select lines for the analog multiplexer |
| out_data | output | OUT_W | Signed decimated word, saturated |
| out_valid | output | 1 | Word is settled and valid |
| out_ch | output | CH_W | Channel of the valid word |

## Verification
The properties assume that `sel_req` and `bit_en` are clean, synchronous levels. They also assume that after reset the first switch request arrives only once `rst` has dropped, so the checks that reach into the past start with known history. The stimulus changes every input at the falling edge and holds it for a full cycle. Some requests are issued with `bit_en` high, which exercises the rule that drops a bit offered during a switch. Between bits, idle cycles toggle `bit_in` with `bit_en` low, so any bit that leaked into the filter would show up in later output words.

// File: rtl/fd_pkg.sv
package fd_pkg;

    // Triangular symmetric weight of tap idx in an ntaps-long line
    function automatic int tap_coef(input int idx, input int ntaps);
        return (idx + 1 < ntaps - idx) ? idx + 1 : ntaps - idx;
    endfunction

    function automatic int coef_sum(input int ntaps);
        int s;
        s = 0;
        for (int i = 0; i < ntaps; i++) s += tap_coef(i, ntaps);
        return s;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    typedef enum logic [1:0] {
        SAT_NONE = 2'd0,
        SAT_POS  = 2'd1,
        SAT_NEG  = 2'd2
    } sat_e;

endpackage

// File: rtl/fd_delay_line.sv
module fd_delay_line #(
    parameter int NTAPS = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift,
    input  logic             din,
    output logic [NTAPS-1:0] taps_next
);
    logic [NTAPS-1:0] taps_q;

    // Tap 0 is the newest bit
    assign taps_next = {taps_q[NTAPS-2:0], din};

    always_ff @(posedge clk) begin
        if (rst)        taps_q <= '0;
        else if (shift) taps_q <= taps_next;
    end
endmodule

// File: rtl/fd_mac.sv
module fd_mac
    import fd_pkg::*;
#(
    parameter int NTAPS = 64,
    parameter int OUT_W = 10
) (
    input  logic [NTAPS-1:0]        taps,
    output logic signed [OUT_W-1:0] sat_out
);
    localparam int SUMC  = coef_sum(NTAPS);
    localparam int ACC_W = max_int($clog2(SUMC + 1) + 1, OUT_W) + 1;
    localparam logic signed [ACC_W-1:0] MAXP = ACC_W'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] MAXN = -ACC_W'(2 ** (OUT_W - 1));

    logic signed [ACC_W-1:0] term [NTAPS];
    logic signed [ACC_W-1:0] acc;
    sat_e                    kind;

    for (genvar g = 0; g < NTAPS; g++) begin : g_term
        localparam logic signed [ACC_W-1:0] CW = ACC_W'(tap_coef(g, NTAPS));
        assign term[g] = taps[g] ? CW : -CW;
    end

    always_comb begin
        acc = '0;
        for (int i = 0; i < NTAPS; i++) acc = acc + term[i];
    end

    always_comb begin
        if (acc > MAXP)      kind = SAT_POS;
        else if (acc < MAXN) kind = SAT_NEG;
        else                 kind = SAT_NONE;
        unique case (kind)
            SAT_POS: sat_out = MAXP[OUT_W-1:0];
            SAT_NEG: sat_out = MAXN[OUT_W-1:0];
            default: sat_out = acc[OUT_W-1:0];
        endcase
    end
endmodule

// File: rtl/fd_flush_ctrl.sv
module fd_flush_ctrl #(
    parameter int NTAPS = 64,
    parameter int DECIM = 8,
    parameter int CH_W  = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bit_en,
    input  logic            sel_req,
    input  logic [CH_W-1:0] sel_ch,
    output logic            accept,
    output logic            fire,
    output logic            settle_now,
    output logic            sel_ack,
    output logic [CH_W-1:0] mux_sel
);
    localparam int CNT_W = $clog2(NTAPS + 1);
    localparam int PH_W  = (DECIM > 1) ? $clog2(DECIM) : 1;

    logic [CNT_W-1:0] cnt;
    logic [PH_W-1:0]  phase;

    assign accept     = bit_en && !sel_req;
    assign fire       = accept && (phase == PH_W'(DECIM - 1));
    assign settle_now = accept && (cnt <= CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= CNT_W'(NTAPS);
            phase   <= '0;
            sel_ack <= 1'b0;
            mux_sel <= '0;
        end else begin
            sel_ack <= sel_req;
            if (sel_req) begin
                cnt     <= CNT_W'(NTAPS);
                phase   <= '0;
                mux_sel <= sel_ch;
            end else if (accept) begin
                if (cnt != '0) cnt <= cnt - 1'b1;
                phase <= (phase == PH_W'(DECIM - 1)) ? '0 : phase + 1'b1;
            end
        end
    end

    // R6: each accepted bit during a flush consumes one count
    assert_flush_decr_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(accept) && $past(cnt) != '0) |-> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/fir_flush_decim.sv
module fir_flush_decim
    import fd_pkg::*;
#(
    parameter int NTAPS = 64,
    parameter int DECIM = 8,
    parameter int OUT_W = 10,
    parameter int CH_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bit_en,
    input  logic                    bit_in,
    input  logic                    sel_req,
    input  logic [CH_W-1:0]         sel_ch,
    output logic                    sel_ack,
    output logic [CH_W-1:0]         mux_sel,
    output logic signed [OUT_W-1:0] out_data,
    output logic                    out_valid,
    output logic [CH_W-1:0]         out_ch
);
    logic             accept, fire, settle_now;
    logic [NTAPS-1:0] taps_next;
    logic signed [OUT_W-1:0] sat_out;

    fd_flush_ctrl #(.NTAPS(NTAPS), .DECIM(DECIM), .CH_W(CH_W)) u_ctrl (
        .clk(clk), .rst(rst), .bit_en(bit_en), .sel_req(sel_req), .sel_ch(sel_ch),
        .accept(accept), .fire(fire), .settle_now(settle_now),
        .sel_ack(sel_ack), .mux_sel(mux_sel)
    );

    fd_delay_line #(.NTAPS(NTAPS)) u_line (
        .clk(clk), .rst(rst), .shift(accept), .din(bit_in), .taps_next(taps_next)
    );

    fd_mac #(.NTAPS(NTAPS), .OUT_W(OUT_W)) u_mac (
        .taps(taps_next), .sat_out(sat_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_data  <= '0;
            out_valid <= 1'b0;
            out_ch    <= '0;
        end else begin
            out_valid <= fire && settle_now;
            if (fire) begin
                out_data <= sat_out;
                out_ch   <= mux_sel;
            end
        end
    end

    // R5: a request is acknowledged and steers the multiplexer on the next cycle
    assert_ack_sel_R5: assert property (@(posedge clk) disable iff (rst)
        sel_req |=> (sel_ack && mux_sel == $past(sel_ch)));

    // R7: a switch always restarts settling, so no valid word follows it
    assert_switch_kills_valid_R7: assert property (@(posedge clk) disable iff (rst)
        sel_req |=> !out_valid);

    // R8: a valid word is tagged with the channel still selected
    assert_tag_matches_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_ch == mux_sel);
endmodule

// File: tb/fir_flush_decim_tb.sv
module fir_flush_decim_tb;
    localparam int NTAPS = 64;
    localparam int DECIM = 8;
    localparam int OUT_W = 10;
    localparam int CH_W  = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_en = 1'b0, bit_in = 1'b0, sel_req = 1'b0;
    logic [CH_W-1:0] sel_ch = '0;
    logic sel_ack, out_valid;
    logic [CH_W-1:0] mux_sel, out_ch;
    logic signed [OUT_W-1:0] out_data;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    bit hist [NTAPS];
    int sinc = 0;
    int cur_ch = 0;

    always #10 clk = ~clk;

    fir_flush_decim #(.NTAPS(NTAPS), .DECIM(DECIM), .OUT_W(OUT_W), .CH_W(CH_W)) u_dut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
        .sel_req(sel_req), .sel_ch(sel_ch), .sel_ack(sel_ack), .mux_sel(mux_sel),
        .out_data(out_data), .out_valid(out_valid), .out_ch(out_ch)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int ref_word();
        int s, w, hi, lo;
        s = 0;
        for (int i = 0; i < NTAPS; i++) begin
            w = (i + 1 < NTAPS - i) ? i + 1 : NTAPS - i;
            s += hist[i] ? w : -w;
        end
        hi = (1 << (OUT_W - 1)) - 1;
        lo = -(1 << (OUT_W - 1));
        if (s > hi) s = hi;
        if (s < lo) s = lo;
        return s;
    endfunction

    // One accepted bit; checks valid, data and tag right after the accepting edge
    task automatic push(input logic b, input string dtag, input string ftag);
        bit ev;
        @(negedge clk);
        bit_in = b; bit_en = 1'b1;
        @(posedge clk); #1;
        bit_en = 1'b0;
        for (int i = NTAPS - 1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = b;
        sinc++;
        @(negedge clk);
        ev = (sinc >= NTAPS) && (sinc % DECIM == 0);
        chk((sinc < NTAPS) ? ftag : "R11", int'(out_valid), int'(ev));
        if (ev) begin
            chk(dtag, int'(out_data), ref_word());
            chk("R8", int'(out_ch), cur_ch);
        end
    endtask

    task automatic switch_to(input int ch, input logic with_bit);
        @(negedge clk);
        sel_req = 1'b1; sel_ch = CH_W'(ch); bit_en = with_bit; bit_in = 1'b1;
        @(posedge clk); #1;
        sel_req = 1'b0; bit_en = 1'b0;
        cur_ch = ch; sinc = 0;
        @(negedge clk);
        chk("R5", int'(sel_ack), 1);
        chk("R5", int'(mux_sel), ch);
        chk("R7", int'(out_valid), 0);
        @(negedge clk);
        chk("R5", int'(sel_ack), 0);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9", int'(out_valid), 0);
        chk("R9", int'(mux_sel), 0);
        chk("R9", int'(sel_ack), 0);
        chk("R9", int'(out_ch), 0);
        chk("R9", int'(out_data), 0);
        rst = 1'b0;
        for (int i = 0; i < NTAPS; i++) hist[i] = 1'b0;
        sinc = 0; cur_ch = 0;
    endtask

    task automatic t_clip_pos();          // channel A, constant ones
        switch_to(1, 1'b0);
        for (int i = 0; i < NTAPS + 16; i++) push(1'b1, "R3", "R6");
    endtask

    task automatic t_mixed();             // channel B, bit offered with request is dropped
        switch_to(2, 1'b1);
        for (int i = 0; i < NTAPS + 24; i++) push(logic'(i % 3 != 2), "R1", "R6");
    endtask

    task automatic t_restart();
        switch_to(3, 1'b0);
        for (int i = 0; i < 40; i++) push(logic'(i % 2), "R1", "R6");
        switch_to(1, 1'b0);
        for (int i = 0; i < NTAPS + 8; i++) push(logic'(i % 5 < 2), "R2", "R7");
    endtask

    task automatic t_clip_neg();
        switch_to(0, 1'b0);
        for (int i = 0; i < NTAPS + 16; i++) push(1'b0, "R4", "R6");
    endtask

    task automatic t_idle();              // bit_in toggles while bit_en is low
        switch_to(2, 1'b0);
        for (int i = 0; i < NTAPS + 16; i++) begin
            push(logic'((i % 4 == 0) || (i % 7 == 1)), "R10", "R6");
            for (int k = 0; k < 2; k++) begin
                @(negedge clk); bit_in = ~bit_in;
                @(negedge clk);
                chk("R10", int'(out_valid), 0);
            end
        end
    endtask

    task automatic t_reset_mid();
        for (int i = 0; i < 20; i++) push(1'b1, "R3", "R6");
        do_reset();
        for (int i = 0; i < NTAPS + 8; i++) push(logic'(i % 6 < 4), "R1", "R9");
    endtask

    initial begin
        for (int i = 0; i < NTAPS; i++) hist[i] = 1'b0;
        repeat (2) @(negedge clk);
        do_reset();
        t_clip_pos();
        t_mixed();
        t_restart();
        t_clip_neg();
        t_idle();
        t_reset_mid();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule